// File: doc/BRIEF.md
# Eight-Times Oversampling Serial Byte Receiver

This block turns an asynchronous serial line into bytes. Its only clock is a sample clock running at eight times the bit rate. An idle line is high. A frame is one low start bit, eight data bits sent least significant first, and one high stop bit. The receiver accepts a start bit only after a run of low samples. It then times every later bit from that point, so each bit is judged near its centre. Each judged data bit enters the top of a shift register and moves down, so the first bit ends up in bit 0.

At the stop bit the block closes the frame with a host handshake. It pulses `word_ready_o` for one sample clock in every case. It sets a sticky overrun flag if the host reported itself busy at that moment. It sets a sticky framing flag if the stop bit read low. Only a frame with neither error is copied into the output byte register.

The back-pressure rule is simple. The host holds `host_busy_i` high while it cannot take a new byte. A frame that ends while the host is busy is dropped and `rx_word_o` keeps its old value. Nothing is stored or retried, so the sender must not outrun the host.

Top module: `uart8x_rx`

## Requirements
- R1: While `rst_n` is low, the block is held idle. `rx_word_o` reads 0x00 and `word_ready_o`, `err_overrun_o` and `err_frame_o` all read 0.
- R2: A start bit is accepted only after four consecutive low samples. The first of these is the sample clock at which the idle receiver first sees the line low.
- R3: If any of the four start samples reads high, the receiver returns to idle. No flag changes, `word_ready_o` stays low and `rx_word_o` is unchanged.
- R4: Bit timing: bit k (k = 0..7 for data, k = 8 for stop) is judged from the line value in the 4th sample clock of its bit period. The start bit's period begins at the first sample clock that sees the line low, and each period is eight sample clocks long.
- R5: Data bits are assembled least significant bit first. A frame carrying 0xB5 (line order 1,0,1,0,1,1,0,1) yields 0xB5.
- R6: At the stop-bit judgement, `word_ready_o` is high for exactly one sample clock, whether or not an error occurred.
- R7: If `host_busy_i` is high at the stop-bit judgement, `err_overrun_o` becomes 1 and the byte is not loaded.
- R8: If the stop bit is judged low, `err_frame_o` becomes 1 and the byte is not loaded. Both flags may be set by the same frame.
- R9: If neither error occurs, the assembled byte appears on `rx_word_o` together with the `word_ready_o` pulse.
- R10: Both error flags hold their value until the next start bit is accepted, and they clear at that acceptance. A rejected start does not clear them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_s | input | 1 | Sample clock, eight times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line_i | input | 1 | Serial input, idle high |
| host_busy_i | input | 1 | High while the host cannot accept a byte |
| word_ready_o | output | 1 | One-cycle pulse at the end of every frame |
| err_overrun_o | output | 1 | Sticky: a frame ended while the host was busy |
| err_frame_o | output | 1 | Sticky: the stop bit was judged low |
| rx_word_o | output | 8 | Last byte received without error |

## Verification
Assertions run on every cycle and guard the local rules:
- a glitch during start validation returns the receiver to idle;
- entry to reception follows a low sample;
- the bit counter never passes the stop position;
- the ready pulse lasts one cycle;
- the byte register moves only at frame end;
- the flags change only at acceptance or frame end;
- a busy host or a low stop bit sets its flag.

Other behaviour can only be shown by the bench scenarios:
- that a whole frame of line activity ends in the right byte with the right bit order;
- that the centre sample lands where R4 places it;
- that a too-short low pulse produces no frame;
- that flags survive idle time and rejected starts, then clear on the next real frame.

// File: rtl/uart8x_rx_pkg.sv
package uart8x_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_RECV  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_s,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_s or negedge rst_n) begin
    if (!rst_n) q[0] <= 1'b1;
    else        q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_s or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b1;
      else        q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart8x_rx_pkg::*;
#(
  parameter int OVS        = 8,
  parameter int DBITS      = 8,
  parameter int START_LOWS = 4
) (
  input  logic clk_s,
  input  logic rst_n,
  input  logic rx_s,
  output logic start_ok_o,
  output logic shift_en_o,
  output logic frame_end_o
);
  localparam int CMAX  = (OVS > START_LOWS) ? OVS : START_LOWS;
  localparam int CNT_W = $clog2(CMAX) + 1;
  localparam int BCW   = $clog2(DBITS + 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_LOWS - 2);
  localparam logic [CNT_W-1:0] SAMP_LAST  = CNT_W'(OVS - 1);
  localparam logic [BCW-1:0]   STOP_IDX   = BCW'(DBITS);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [BCW-1:0]   bcnt;
  logic             take;

  assign start_ok_o  = (state == ST_START) && !rx_s && (cnt == START_LAST);
  assign take        = (state == ST_RECV) && (cnt == SAMP_LAST);
  assign shift_en_o  = take && (bcnt < STOP_IDX);
  assign frame_end_o = take && (bcnt == STOP_IDX);

  always_ff @(posedge clk_s or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!rx_s) state <= ST_START;
        end
        ST_START: begin
          if (rx_s) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (start_ok_o) begin
            state <= ST_RECV;
            cnt   <= '0;
            bcnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RECV: begin
          if (take) begin
            cnt <= '0;
            if (frame_end_o) begin
              bcnt  <= '0;
              state <= ST_IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
          bcnt  <= '0;
        end
      endcase
    end
  end

  AST_GLITCH_ABORTS: assert property (@(posedge clk_s) disable iff (!rst_n)
    (state == ST_START && rx_s) |=> (state == ST_IDLE)); // R3
  AST_RECV_AFTER_LOW: assert property (@(posedge clk_s) disable iff (!rst_n)
    (state == ST_RECV && $past(state) == ST_START) |-> !$past(rx_s)); // R2
  AST_BITCNT_BOUND: assert property (@(posedge clk_s) disable iff (!rst_n)
    bcnt <= STOP_IDX); // R4
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int DBITS = 8
) (
  input  logic             clk_s,
  input  logic             rst_n,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [DBITS-1:0] data_o
);
  always_ff @(posedge clk_s or negedge rst_n) begin
    if (!rst_n)          data_o <= '0;
    else if (shift_en_i) data_o <= {bit_i, data_o[DBITS-1:1]};
  end
endmodule

// File: rtl/rx_host_port.sv
module rx_host_port #(
  parameter int DBITS = 8
) (
  input  logic             clk_s,
  input  logic             rst_n,
  input  logic             start_ok_i,
  input  logic             frame_end_i,
  input  logic             line_bit_i,
  input  logic             host_busy_i,
  input  logic [DBITS-1:0] shreg_i,
  output logic             ready_o,
  output logic             err_ov_o,
  output logic             err_fr_o,
  output logic [DBITS-1:0] word_o
);
  always_ff @(posedge clk_s or negedge rst_n) begin
    if (!rst_n) begin
      ready_o  <= 1'b0;
      err_ov_o <= 1'b0;
      err_fr_o <= 1'b0;
      word_o   <= '0;
    end else begin
      ready_o <= frame_end_i;
      if (start_ok_i) begin
        err_ov_o <= 1'b0;
        err_fr_o <= 1'b0;
      end
      if (frame_end_i) begin
        err_ov_o <= host_busy_i;
        err_fr_o <= !line_bit_i;
        if (!host_busy_i && line_bit_i) word_o <= shreg_i;
      end
    end
  end

  AST_READY_SINGLE: assert property (@(posedge clk_s) disable iff (!rst_n)
    ready_o |=> !ready_o); // R6
  AST_WORD_ONLY_AT_END: assert property (@(posedge clk_s) disable iff (!rst_n)
    !frame_end_i |=> $stable(word_o)); // R9
  AST_FLAGS_STICKY: assert property (@(posedge clk_s) disable iff (!rst_n)
    (!start_ok_i && !frame_end_i) |=> ($stable(err_ov_o) && $stable(err_fr_o))); // R10
  AST_BUSY_SETS_OV: assert property (@(posedge clk_s) disable iff (!rst_n)
    (frame_end_i && host_busy_i) |=> err_ov_o); // R7
  AST_LOW_STOP_SETS_FR: assert property (@(posedge clk_s) disable iff (!rst_n)
    (frame_end_i && !line_bit_i) |=> err_fr_o); // R8
endmodule

// File: rtl/uart8x_rx.sv
module uart8x_rx #(
  parameter int OVS         = 8,
  parameter int DBITS       = 8,
  parameter int START_LOWS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_s,
  input  logic             rst_n,
  input  logic             rx_line_i,
  input  logic             host_busy_i,
  output logic             word_ready_o,
  output logic             err_overrun_o,
  output logic             err_frame_o,
  output logic [DBITS-1:0] rx_word_o
);
  logic             rx_s;
  logic             start_ok;
  logic             shift_en;
  logic             frame_end;
  logic [DBITS-1:0] shreg;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_s (clk_s),
    .rst_n (rst_n),
    .d_i   (rx_line_i),
    .q_o   (rx_s)
  );

  rx_frame_ctrl #(.OVS(OVS), .DBITS(DBITS), .START_LOWS(START_LOWS)) u_ctrl (
    .clk_s       (clk_s),
    .rst_n       (rst_n),
    .rx_s        (rx_s),
    .start_ok_o  (start_ok),
    .shift_en_o  (shift_en),
    .frame_end_o (frame_end)
  );

  rx_shifter #(.DBITS(DBITS)) u_shift (
    .clk_s      (clk_s),
    .rst_n      (rst_n),
    .shift_en_i (shift_en),
    .bit_i      (rx_s),
    .data_o     (shreg)
  );

  rx_host_port #(.DBITS(DBITS)) u_host (
    .clk_s       (clk_s),
    .rst_n       (rst_n),
    .start_ok_i  (start_ok),
    .frame_end_i (frame_end),
    .line_bit_i  (rx_s),
    .host_busy_i (host_busy_i),
    .shreg_i     (shreg),
    .ready_o     (word_ready_o),
    .err_ov_o    (err_overrun_o),
    .err_fr_o    (err_frame_o),
    .word_o      (rx_word_o)
  );
endmodule

// File: tb/tb_uart8x_rx.sv
module tb_uart8x_rx;
  logic       clk_s = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line_i = 1'b1;
  logic       host_busy_i = 1'b0;
  logic       word_ready_o;
  logic       err_overrun_o;
  logic       err_frame_o;
  logic [7:0] rx_word_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0] d;
    logic       ov;
    logic       fr;
  } exp_t;

  exp_t       sb_q[$];
  exp_t       mon_e;
  logic [7:0] exp_word = 8'h00;

  uart8x_rx dut (
    .clk_s         (clk_s),
    .rst_n         (rst_n),
    .rx_line_i     (rx_line_i),
    .host_busy_i   (host_busy_i),
    .word_ready_o  (word_ready_o),
    .err_overrun_o (err_overrun_o),
    .err_frame_o   (err_frame_o),
    .rx_word_o     (rx_word_o)
  );

  always #4 clk_s = ~clk_s;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_line_i = v;
    repeat (n) @(negedge clk_s);
  endtask

  // Called at a negedge. Drives one full frame and pushes the expected result.
  task automatic send_frame(input logic [7:0] d, input logic stop_ok, input logic busy);
    exp_t e;
    e.d  = d;
    e.ov = busy;
    e.fr = !stop_ok;
    sb_q.push_back(e);
    host_busy_i = busy;
    hold(1'b0, 8);
    for (int i = 0; i < 8; i++) begin
      hold(d[i], 8);
      if (i == 0) begin
        check("R10 overrun flag cleared on accepted start", err_overrun_o, 0);
        check("R10 frame flag cleared on accepted start", err_frame_o, 0);
      end
    end
    if (stop_ok) hold(1'b1, 8);
    else begin
      hold(1'b0, 4);
      hold(1'b1, 4);
    end
    hold(1'b1, 8);
    host_busy_i = 1'b0;
    hold(1'b1, 8);
  endtask

  // Scoreboard monitor
  always @(negedge clk_s) begin
    if (rst_n && word_ready_o) begin
      if (sb_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R6 unexpected word_ready_o actual=1 expected=0");
      end else begin
        mon_e = sb_q.pop_front();
        if (!mon_e.ov && !mon_e.fr) exp_word = mon_e.d;
        check("R7 overrun flag at frame end", err_overrun_o, mon_e.ov);
        check("R8 framing flag at frame end", err_frame_o, mon_e.fr);
        check("R9 R5 received word", rx_word_o, exp_word);
      end
    end
  end

  // R6: the pulse lasts exactly one sample clock
  logic prev_ready = 1'b0;
  always @(negedge clk_s) begin
    if (rst_n && prev_ready && word_ready_o) begin
      checks++;
      failures++;
      $display("FAIL R6 ready longer than one cycle actual=1 expected=0");
    end
    prev_ready = word_ready_o;
  end

  initial begin
    repeat (50000) @(posedge clk_s);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_s);
    check("R1 word in reset", rx_word_o, 8'h00);
    check("R1 ready in reset", word_ready_o, 0);
    check("R1 overrun in reset", err_overrun_o, 0);
    check("R1 frame in reset", err_frame_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_s);

    send_frame(8'hB5, 1'b1, 1'b0);  // R5 R9
    send_frame(8'h00, 1'b1, 1'b0);
    send_frame(8'hFF, 1'b1, 1'b0);
    send_frame(8'h5A, 1'b1, 1'b0);
    send_frame(8'h81, 1'b1, 1'b1);  // R7 busy host
    check("R10 overrun held in idle", err_overrun_o, 1);
    send_frame(8'hC3, 1'b0, 1'b0);  // R8 low stop
    hold(1'b1, 40);
    check("R10 frame flag held in idle", err_frame_o, 1);
    check("R10 overrun replaced at frame end", err_overrun_o, 0);

    // R2 R3: low run of three samples is rejected
    hold(1'b0, 3);
    hold(1'b1, 120);
    check("R3 no frame after glitch", sb_q.size(), 0);
    check("R3 R10 frame flag kept after glitch", err_frame_o, 1);
    check("R3 word unchanged after glitch", rx_word_o, exp_word);

    send_frame(8'h3C, 1'b0, 1'b1);  // R7 R8 both
    send_frame(8'h96, 1'b1, 1'b0);  // R4 clean after errors
    check("R9 flags clear after clean frame", {err_overrun_o, err_frame_o}, 0);
    send_frame(8'h01, 1'b1, 1'b0);
    send_frame(8'h80, 1'b1, 1'b0);
    hold(1'b1, 20);
    check("R6 every frame produced a ready pulse", sb_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule